// File: doc/BRIEF.md
# Converter core reset sequencer

This block brings an analog-to-digital capture core out of reset in a safe order. Software writes a small run-control word over a 32-bit word-addressed register bus. That word drives three controls: a release for the clock manager, a release for the capture datapath, and an active-low clock gate. The block watches a lock indication from the clock manager. It releases the datapath only once the clock manager is out of reset and lock has been qualified. The qualified lock is reported in a status word.

Power-up leaves everything held: the clock manager and the datapath stay in reset and the capture clock is gated. The register bus stays fully usable in that state. Writing zero to the run-control word returns the core to the same held state at any time. Builds that have no dynamic clock reconfiguration select a variant in which lock reads as set as soon as the clock manager is released.

Top module: `conv_rst_seq`

## Requirements
- R1: After reset, `mgr_rst_n`, `dp_rst_n` and `clk_en` are low, and the run-control word reads 0.
- R2: The run-control word sits at word address 0x010 (byte 0x40). Bit 0 is the datapath release, bit 1 the clock-manager release and bit 2 the active-low clock gate. It reads back with bits 31:3 zero in every state. Read data appears on `rd_data` in the cycle after `rd_en` and is 0 otherwise, and an unmapped address reads 0.
- R3: `mgr_rst_n` takes the value of bit 1 at the clock edge that samples the write.
- R4: The lock status is bit 17 of the word at word address 0x01D (byte 0x74). With reconfiguration present, it sets at the LOCK_CYCLES-th consecutive edge at which `lock_in` is high and bit 1 is set. It clears at the first edge at which `lock_in` is low.
- R5: A write that clears bit 1 clears the lock status and drives `dp_rst_n` low at the same edge that drives `mgr_rst_n` low.
- R6: `dp_rst_n` is high only while bit 0, bit 1 and the lock status are all set. Setting bit 0 before lock has no effect until lock arrives.
- R7: Writing 0 to the run-control word drives all three outputs low.
- R8: `clk_en` is high exactly when `dp_rst_n` is high and bit 2 is clear.
- R9: With HAS_RECONFIG=0, the lock status follows bit 1 at the write edge, whatever `lock_in` does.
- R10: A write to any address other than the run-control word leaves it and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address for reads and writes |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | DATA_W | Read data, one cycle after `rd_en` |
| lock_in | input | 1 | Lock indication from the clock manager |
| mgr_rst_n | output | 1 | Active-low clock-manager reset |
| dp_rst_n | output | 1 | Active-low datapath reset |
| clk_en | output | 1 | Capture clock enable |

## Verification
The hardest situation to reach is the exact edge at which lock qualifies. At that edge, `dp_rst_n` must rise precisely on the LOCK_CYCLES-th high sample, never one edge early, and a single low sample must restart the count. The stimulus holds bit 0 set while `lock_in` is low. It then raises `lock_in` and samples `dp_rst_n` after LOCK_CYCLES-1 edges and again after LOCK_CYCLES edges. It then drops lock for a single cycle and repeats the count, and finally re-releases the clock manager while lock is already high, so that the write edge itself counts as the first sample. A long random phase toggles `lock_in` slowly enough that qualification is reached and broken many times. Throughout that phase, a behavioural model checks both the lock-present and the lock-free variants on every clock.

// File: rtl/conv_rst_seq_pkg.sv
package conv_rst_seq_pkg;
  // byte offsets of the two words; word addresses are derived in the top
  localparam int unsigned RUN_BYTE_OFS  = 32'h40;
  localparam int unsigned STAT_BYTE_OFS = 32'h74;
  localparam int unsigned LOCK_BIT_POS  = 17;

  // run-control word, bit 2 down to bit 0
  typedef struct packed {
    logic clk_gate_n;  // 1 gates the capture clock
    logic mgr_run;     // 1 releases the clock manager
    logic dp_run;      // 1 releases the datapath
  } run_ctrl_t;

  localparam int unsigned RUN_W = $bits(run_ctrl_t);
endpackage

// File: rtl/crs_regbank.sv
module crs_regbank
  import conv_rst_seq_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned RUN_ADDR = 16,
  parameter int unsigned STAT_ADDR = 29,
  parameter int unsigned LOCK_POS = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              lock_q,
  output run_ctrl_t         ctrl_q,
  output run_ctrl_t         ctrl_d,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] RUN_A  = ADDR_W'(RUN_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic              run_hit;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wr_hi;

  assign run_hit      = wr_en && (addr == RUN_A);
  assign unused_wr_hi = ^wr_data[DATA_W-1:RUN_W];

  always_comb begin
    ctrl_d = ctrl_q;
    if (run_hit) ctrl_d = run_ctrl_t'(wr_data[RUN_W-1:0]);
  end

  always_comb begin
    rd_mux = '0;
    if (addr == RUN_A)       rd_mux = DATA_W'(ctrl_q);
    else if (addr == STAT_A) rd_mux = DATA_W'(lock_q) << LOCK_POS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      rd_data <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      rd_data <= rd_en ? rd_mux : '0;
    end
  end

  // R10
  foreign_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != RUN_A) |=> $stable(ctrl_q));
  // R2
  run_rd_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == RUN_A) |=> (rd_data[DATA_W-1:RUN_W] == '0));
  // R2
  idle_rd_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));
endmodule

// File: rtl/crs_lock_qual.sv
module crs_lock_qual #(
  parameter int unsigned LOCK_CYCLES  = 4,
  parameter bit          HAS_RECONFIG = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic mgr_run_d,
  input  logic lock_in,
  output logic lock_d,
  output logic lock_q
);
  localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             counted;

  // consecutive-sample counter, saturating at LOCK_CYCLES
  always_comb begin
    if (!mgr_run_d || !lock_in) cnt_d = '0;
    else if (cnt_q == CNT_MAX)  cnt_d = cnt_q;
    else                        cnt_d = cnt_q + 1'b1;
  end
  assign counted = (cnt_d == CNT_MAX);

  generate
    if (HAS_RECONFIG) begin : g_qualified
      assign lock_d = counted;
    end else begin : g_fixed
      assign lock_d = mgr_run_d;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  generate
    if (HAS_RECONFIG) begin : g_lock_chk
      // R4
      lock_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> $past(lock_in));
      // R4
      lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !lock_in |=> !lock_q);
    end
  endgenerate
endmodule

// File: rtl/crs_out_stage.sv
module crs_out_stage
  import conv_rst_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  run_ctrl_t ctrl_d,
  input  logic      lock_d,
  output logic      mgr_rst_n,
  output logic      dp_rst_n,
  output logic      clk_en
);
  logic dp_go;
  assign dp_go = ctrl_d.dp_run && ctrl_d.mgr_run && lock_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      mgr_rst_n <= 1'b0;
      dp_rst_n  <= 1'b0;
      clk_en    <= 1'b0;
    end else begin
      mgr_rst_n <= ctrl_d.mgr_run;
      dp_rst_n  <= dp_go;
      clk_en    <= dp_go && !ctrl_d.clk_gate_n;
    end
  end

  // R6
  dp_under_mgr_chk: assert property (@(posedge clk) disable iff (rst)
    dp_rst_n |-> mgr_rst_n);
  // R8
  ce_under_dp_chk: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> dp_rst_n);
endmodule

// File: rtl/conv_rst_seq.sv
module conv_rst_seq
  import conv_rst_seq_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned ADDR_W       = 10,
  parameter int unsigned LOCK_CYCLES  = 4,
  parameter bit          HAS_RECONFIG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              lock_in,
  output logic              mgr_rst_n,
  output logic              dp_rst_n,
  output logic              clk_en
);
  localparam int unsigned RUN_WADDR  = RUN_BYTE_OFS / (DATA_W / 8);
  localparam int unsigned STAT_WADDR = STAT_BYTE_OFS / (DATA_W / 8);

  run_ctrl_t ctrl_q, ctrl_d;
  logic      lock_d, lock_q;

  crs_regbank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RUN_ADDR(RUN_WADDR),
    .STAT_ADDR(STAT_WADDR), .LOCK_POS(LOCK_BIT_POS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .lock_q(lock_q), .ctrl_q(ctrl_q), .ctrl_d(ctrl_d),
    .rd_data(rd_data)
  );

  crs_lock_qual #(
    .LOCK_CYCLES(LOCK_CYCLES), .HAS_RECONFIG(HAS_RECONFIG)
  ) u_lock (
    .clk(clk), .rst(rst), .mgr_run_d(ctrl_d.mgr_run), .lock_in(lock_in),
    .lock_d(lock_d), .lock_q(lock_q)
  );

  crs_out_stage u_out (
    .clk(clk), .rst(rst), .ctrl_d(ctrl_d), .lock_d(lock_d),
    .mgr_rst_n(mgr_rst_n), .dp_rst_n(dp_rst_n), .clk_en(clk_en)
  );

  // R5
  lock_needs_mgr_chk: assert property (@(posedge clk) disable iff (rst)
    !mgr_rst_n |-> !lock_q);
  // R6
  dp_rise_locked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dp_rst_n) |-> lock_q);
  // R3
  mgr_follow_chk: assert property (@(posedge clk) disable iff (rst)
    mgr_rst_n |-> ctrl_q.mgr_run);
endmodule

// File: tb/conv_rst_seq_test.sv
`timescale 1ns/1ps
module conv_rst_seq_test;
  localparam int L = 4;
  localparam logic [9:0] RUN_A  = 10'h010;
  localparam logic [9:0] STAT_A = 10'h01D;
  localparam logic [31:0] LOCKED = 32'h0002_0000;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, lock_in = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_a, rd_b;
  logic mgr_a, dp_a, ce_a, mgr_b, dp_b, ce_b;

  always #2 clk = ~clk;

  conv_rst_seq #(.LOCK_CYCLES(L), .HAS_RECONFIG(1'b1)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_a), .lock_in(lock_in),
    .mgr_rst_n(mgr_a), .dp_rst_n(dp_a), .clk_en(ce_a));

  conv_rst_seq #(.LOCK_CYCLES(L), .HAS_RECONFIG(1'b0)) uut_nr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_b), .lock_in(lock_in),
    .mgr_rst_n(mgr_b), .dp_rst_n(dp_b), .clk_en(ce_b));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference, index 0 = lock qualified, 1 = lock-free variant
  int          m_ctrl[2];
  int          m_cnt[2];
  bit          m_lock[2], m_mgr[2], m_dp[2], m_ce[2];
  logic [31:0] m_rd[2];

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        m_ctrl[i] = 0; m_cnt[i] = 0; m_lock[i] = 0;
        m_mgr[i] = 0; m_dp[i] = 0; m_ce[i] = 0; m_rd[i] = 0;
      end else begin
        if (!rd_en)              m_rd[i] = 0;
        else if (addr == RUN_A)  m_rd[i] = m_ctrl[i];
        else if (addr == STAT_A) m_rd[i] = m_lock[i] ? LOCKED : 0;
        else                     m_rd[i] = 0;
        if (wr_en && addr == RUN_A) m_ctrl[i] = int'(wr_data[2:0]);
        if (((m_ctrl[i] >> 1) & 1) == 0 || !lock_in) m_cnt[i] = 0;
        else if (m_cnt[i] < L) m_cnt[i]++;
        if (i == 0) m_lock[i] = (m_cnt[i] == L);
        else        m_lock[i] = ((m_ctrl[i] >> 1) & 1) == 1;
        m_mgr[i] = ((m_ctrl[i] >> 1) & 1) == 1;
        m_dp[i]  = m_mgr[i] && ((m_ctrl[i] & 1) == 1) && m_lock[i];
        m_ce[i]  = m_dp[i] && ((m_ctrl[i] >> 2) & 1) == 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R3", "model mgr_rst_n", mgr_a, m_mgr[0]);
      chk("R6", "model dp_rst_n", dp_a, m_dp[0]);
      chk("R8", "model clk_en", ce_a, m_ce[0]);
      chk("R2", "model rd_data", rd_a, m_rd[0]);
      chk("R9", "model nr mgr_rst_n", mgr_b, m_mgr[1]);
      chk("R9", "model nr dp_rst_n", dp_b, m_dp[1]);
      chk("R9", "model nr clk_en", ce_b, m_ce[1]);
      chk("R9", "model nr rd_data", rd_b, m_rd[1]);
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] va,
                    output logic [31:0] vb);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; va = rd_a; vb = rd_b;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    logic [31:0] va, vb;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 held state after reset
    chk("R1", "mgr_rst_n", mgr_a, 0);
    chk("R1", "dp_rst_n", dp_a, 0);
    chk("R1", "clk_en", ce_a, 0);
    rd(RUN_A, va, vb);
    chk("R1", "run word", va, 0);

    wr(RUN_A, 32'hFFFF_FFF2);
    chk("R3", "mgr released", mgr_a, 1);
    chk("R6", "dp held", dp_a, 0);
    rd(RUN_A, va, vb);
    chk("R2", "upper bits zero", va, 2);
    rd(STAT_A, va, vb);
    chk("R4", "no lock yet", va, 0);
    chk("R9", "lock-free status", vb, LOCKED);

    wr(RUN_A, 3);
    chk("R6", "dp waits for lock", dp_a, 0);
    chk("R9", "lock-free dp", dp_b, 1);

    @(negedge clk); lock_in = 1'b1;
    repeat (L - 1) @(negedge clk);
    chk("R4", "one edge short", dp_a, 0);
    @(negedge clk);
    chk("R6", "dp on lock", dp_a, 1);
    chk("R8", "clk on", ce_a, 1);
    rd(STAT_A, va, vb);
    chk("R4", "lock status", va, LOCKED);

    wr(RUN_A, 7);
    chk("R8", "clock gated", ce_a, 0);
    chk("R8", "dp kept", dp_a, 1);
    wr(RUN_A, 3);
    chk("R8", "clock ungated", ce_a, 1);

    wr(10'h011, 0);
    chk("R10", "dp after foreign write", dp_a, 1);
    rd(RUN_A, va, vb);
    chk("R10", "run word kept", va, 3);
    rd(10'h011, va, vb);
    chk("R2", "unmapped read", va, 0);

    @(negedge clk); lock_in = 1'b0;
    @(negedge clk);
    chk("R4", "dp on lock loss", dp_a, 0);
    rd(STAT_A, va, vb);
    chk("R4", "status on lock loss", va, 0);
    lock_in = 1'b1;
    repeat (L) @(negedge clk);
    chk("R4", "relock", dp_a, 1);

    wr(RUN_A, 1);
    chk("R5", "dp on mgr clear", dp_a, 0);
    chk("R5", "mgr on clear", mgr_a, 0);
    rd(STAT_A, va, vb);
    chk("R5", "status on clear", va, 0);
    rd(RUN_A, va, vb);
    chk("R2", "readable while held", va, 1);

    wr(RUN_A, 3);
    chk("R4", "write edge counts first", dp_a, 0);
    repeat (L - 1) @(negedge clk);
    chk("R4", "relock after release", dp_a, 1);

    wr(RUN_A, 0);
    chk("R7", "mgr off", mgr_a, 0);
    chk("R7", "dp off", dp_a, 0);
    chk("R7", "clk off", ce_a, 0);
    chk("R7", "nr dp off", dp_b, 0);

    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      wr_en = ($urandom_range(0, 7) == 0);
      rd_en = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 3))
        0, 1: addr = RUN_A;
        2:    addr = STAT_A;
        default: addr = 10'h011;
      endcase
      wr_data = $urandom;
      if ($urandom_range(0, 9) == 0) lock_in = ~lock_in;
      rst = ($urandom_range(0, 499) == 0);
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; rst = 1'b0;
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule